// File: doc/BRIEF.md
# Chip Select and Wait State Generator

This block sits on an external memory bus and turns each bus cycle's 32-bit address and 6-bit address-space identifier (ASI) into one of six active-low chip selects. Every area has a base register and a mask register. The ASI and the upper sixteen address bits are compared together against the base, bit by bit. Any bit set in the mask is left out of the comparison. When several areas match, the lowest-numbered one takes the cycle.

For the area it selects, the block also ends each data beat. A per-area wait configuration holds a wait count for the first beat, a separate wait count for every later beat of a burst, an enable for internal wait generation and an early-ready override. With internal waits disabled, only the external active-low ready input ends a beat. With the override set, whichever ready comes first ends it. The configuration is captured when the cycle starts. A register write made during a cycle therefore takes effect from the next cycle on.

Top module: `cs_wait_gen`

## Requirements
- R1: During and right after reset, all selects are high and ready is low. Area 0 comes out of reset valid with base 0 and mask 0x00030001, so it matches ASI 0..3 at addresses whose bits 31:17 are zero. Its wait configuration is: internal waits on, first count 7, burst count 7, override off. Areas 1..5 come out of reset invalid and never match.
- R2: Register writes use `reg_kind_i`. Kind 0 is the base register: bit 31 valid, bits 21:16 ASI, bits 15:0 address bits 31:16. Kind 1 is the mask register: bits 21:16 ASI mask, bits 15:0 address mask. Kind 2 is the wait configuration: bits 3:0 first count, bits 7:4 burst count, bit 8 override, bit 9 wait enable.
- R3: An area matches when it is valid and every ASI bit and address bit 31:16 whose mask bit is 0 equals the base bit. A mask bit of 1 excludes that bit from the comparison.
- R4: When more than one area matches, the lowest-numbered area is selected.
- R5: When `cyc_start_i` is sampled high at a clock edge with a matching area and no cycle in progress, exactly that area's select goes low from the next cycle and stays low until the cycle ends. With no match, all selects stay high and ready never rises.
- R6: With wait enable set, the first beat has first-count+1 wait cycles. Ready is high in cycle first-count+2 of the select being low.
- R7: If `burst_more_i` is high while ready is high, the select stays low and a new beat starts. That beat has burst-count+1 wait cycles.
- R8: With wait enable clear, a beat ends only on external ready. `ready_o` is high in the same cycle in which `ext_ready_n_i` is low during a cycle.
- R9: With wait enable set and override clear, external ready has no effect on beat length.
- R10: With wait enable and override both set, a beat ends on the earlier of external ready and the internal count.
- R11: When ready is high with `burst_more_i` low, all selects are high in the next cycle.
- R12: Writes with area index 6 or 7, or with kind 3, change nothing. A write made during a cycle does not change that cycle's beat lengths.
- R13: `cyc_start_i` is ignored while a cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 32 | Bus address |
| asi_i | input | 6 | Address-space identifier |
| cyc_start_i | input | 1 | Cycle start strobe, one cycle wide |
| burst_more_i | input | 1 | Another beat follows the current one |
| ext_ready_n_i | input | 1 | External active-low ready |
| reg_we_i | input | 1 | Register write enable |
| reg_area_i | input | 3 | Area index of the write |
| reg_kind_i | input | 2 | Register kind: 0 base, 1 mask, 2 wait, 3 none |
| reg_wdata_i | input | 32 | Register write data |
| cs_n_o | output | 6 | Active-low chip selects, bit n for area n |
| ready_o | output | 1 | Internal ready that ends the current beat |

## Verification
The assertions take for granted that every input carries a known level in every cycle after reset. They also assume that `burst_more_i` is only meaningful in the cycle in which ready is high. On that basis they check that at most one select is low, that the select holds steady between readies, and that ready only appears while a select is low. The bench drives all inputs from the first clock and only raises `burst_more_i` for beats that it means to continue. It raises a cycle start during a cycle only in the deliberate R13 test, and in every other case it waits until it has seen all selects high first.

// File: rtl/csw_pkg.sv
package csw_pkg;

    localparam int WORD_W    = 32;
    localparam int ASI_W     = 6;
    localparam int TAG_W     = 16;
    localparam int CNT_W     = 4;

    // register word layout
    localparam int ASI_LSB   = 16;
    localparam int VALID_BIT = 31;
    localparam int BURST_LSB = CNT_W;
    localparam int OVR_BIT   = 2 * CNT_W;
    localparam int WEN_BIT   = 2 * CNT_W + 1;

    typedef struct packed {
        logic             valid;
        logic [ASI_W-1:0] asi;
        logic [TAG_W-1:0] tag;
    } base_t;

    typedef struct packed {
        logic [ASI_W-1:0] asi;
        logic [TAG_W-1:0] tag;
    } mask_t;

    typedef struct packed {
        logic             wait_en;
        logic             early_ok;
        logic [CNT_W-1:0] burst_cnt;
        logic [CNT_W-1:0] first_cnt;
    } wcfg_t;

    typedef enum logic [1:0] {
        K_BASE = 2'd0,
        K_MASK = 2'd1,
        K_WAIT = 2'd2,
        K_NONE = 2'd3
    } reg_kind_e;

    localparam base_t BOOT_BASE = '{valid: 1'b1, asi: '0, tag: '0};
    localparam mask_t BOOT_MASK = '{asi: 6'h03, tag: 16'h0001};
    localparam wcfg_t BOOT_WCFG = '{wait_en: 1'b1, early_ok: 1'b0,
                                    burst_cnt: 4'd7, first_cnt: 4'd7};

endpackage

// File: rtl/csw_regs.sv
module csw_regs
    import csw_pkg::*;
#(
    parameter int NUM_AREAS = 6,
    parameter int IDX_W     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [IDX_W-1:0]        area_i,
    input  logic [1:0]              kind_i,
    input  logic [WORD_W-1:0]       wdata_i,
    output base_t [NUM_AREAS-1:0]   base_o,
    output mask_t [NUM_AREAS-1:0]   mask_o,
    output wcfg_t [NUM_AREAS-1:0]   wcfg_o
);

    localparam int GAP_LSB = ASI_LSB + ASI_W;
    localparam int GAP_MSB = VALID_BIT - 1;

    typedef struct packed {
        base_t [NUM_AREAS-1:0] base;
        mask_t [NUM_AREAS-1:0] mask;
        wcfg_t [NUM_AREAS-1:0] wcfg;
    } regs_t;

    function automatic regs_t reset_image();
        regs_t r;
        r         = '0;
        r.base[0] = BOOT_BASE;
        r.mask[0] = BOOT_MASK;
        r.wcfg[0] = BOOT_WCFG;
        return r;
    endfunction

    regs_t     regs_d, regs_q;
    reg_kind_e kind;
    base_t     wr_base;
    mask_t     wr_mask;
    wcfg_t     wr_wcfg;
    logic      unused_gap;

    assign kind       = reg_kind_e'(kind_i);
    assign unused_gap = ^wdata_i[GAP_MSB:GAP_LSB];

    always_comb begin
        wr_base.valid     = wdata_i[VALID_BIT];
        wr_base.asi       = wdata_i[ASI_LSB +: ASI_W];
        wr_base.tag       = wdata_i[TAG_W-1:0];
        wr_mask.asi       = wdata_i[ASI_LSB +: ASI_W];
        wr_mask.tag       = wdata_i[TAG_W-1:0];
        wr_wcfg.wait_en   = wdata_i[WEN_BIT];
        wr_wcfg.early_ok  = wdata_i[OVR_BIT];
        wr_wcfg.burst_cnt = wdata_i[BURST_LSB +: CNT_W];
        wr_wcfg.first_cnt = wdata_i[CNT_W-1:0];
    end

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            for (int i = 0; i < NUM_AREAS; i++) begin
                if (int'(area_i) == i) begin
                    case (kind)
                        K_BASE:  regs_d.base[i] = wr_base;
                        K_MASK:  regs_d.mask[i] = wr_mask;
                        K_WAIT:  regs_d.wcfg[i] = wr_wcfg;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= reset_image();
        else        regs_q <= regs_d;
    end

    assign base_o = regs_q.base;
    assign mask_o = regs_q.mask;
    assign wcfg_o = regs_q.wcfg;

endmodule

// File: rtl/csw_decode.sv
module csw_decode
    import csw_pkg::*;
#(
    parameter int NUM_AREAS = 6,
    parameter int IDX_W     = 3
) (
    input  logic [TAG_W-1:0]        tag_i,
    input  logic [ASI_W-1:0]        asi_i,
    input  base_t [NUM_AREAS-1:0]   base_i,
    input  mask_t [NUM_AREAS-1:0]   mask_i,
    output logic                    hit_o,
    output logic [IDX_W-1:0]        idx_o,
    output logic [NUM_AREAS-1:0]    sel_o
);

    logic [NUM_AREAS-1:0] match;

    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_cmp
        logic asi_ok;
        logic tag_ok;
        assign asi_ok   = ((asi_i ^ base_i[g].asi) & ~mask_i[g].asi) == '0;
        assign tag_ok   = ((tag_i ^ base_i[g].tag) & ~mask_i[g].tag) == '0;
        assign match[g] = base_i[g].valid & asi_ok & tag_ok;
    end

    // lowest index wins: scan downward so the last write is the lowest
    always_comb begin
        idx_o = '0;
        sel_o = '0;
        for (int i = NUM_AREAS - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx_o    = IDX_W'(i);
                sel_o    = '0;
                sel_o[i] = 1'b1;
            end
        end
    end

    assign hit_o = |match;

endmodule

// File: rtl/csw_beat.sv
module csw_beat
    import csw_pkg::*;
#(
    parameter int NUM_AREAS = 6,
    parameter int IDX_W     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    hit_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [NUM_AREAS-1:0]    sel_i,
    input  wcfg_t [NUM_AREAS-1:0]   wcfg_i,
    input  logic                    more_i,
    input  logic                    ext_rdy_n_i,
    output logic [NUM_AREAS-1:0]    sel_o,
    output logic                    rdy_o
);

    localparam int TMR_W = CNT_W + 1;

    typedef struct packed {
        logic                 active;
        logic [NUM_AREAS-1:0] sel;
        logic                 wait_en;
        logic                 early_ok;
        logic [CNT_W-1:0]     burst_cnt;
        logic [TMR_W-1:0]     tmr;
    } beat_t;

    beat_t st_d, st_q;
    wcfg_t cfg;
    logic  int_done;
    logic  ext_done;
    logic  rdy;

    assign cfg      = wcfg_i[idx_i];
    assign int_done = st_q.wait_en && (st_q.tmr == '0);
    assign ext_done = !ext_rdy_n_i && (!st_q.wait_en || st_q.early_ok);
    assign rdy      = st_q.active && (int_done || ext_done);

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (start_i && hit_i) begin
                st_d.active    = 1'b1;
                st_d.sel       = sel_i;
                st_d.wait_en   = cfg.wait_en;
                st_d.early_ok  = cfg.early_ok;
                st_d.burst_cnt = cfg.burst_cnt;
                st_d.tmr       = TMR_W'(cfg.first_cnt) + TMR_W'(1);
            end
        end else if (rdy) begin
            if (more_i) begin
                st_d.tmr = TMR_W'(st_q.burst_cnt) + TMR_W'(1);
            end else begin
                st_d.active = 1'b0;
                st_d.sel    = '0;
                st_d.tmr    = '0;
            end
        end else if (st_q.tmr != '0) begin
            st_d.tmr = st_q.tmr - TMR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_o = st_q.sel;
    assign rdy_o = rdy;

endmodule

// File: rtl/cs_wait_gen.sv
module cs_wait_gen
    import csw_pkg::*;
#(
    parameter  int NUM_AREAS = 6,
    parameter  int ADDR_W    = 32,
    localparam int IDX_W     = $clog2(NUM_AREAS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [ASI_W-1:0]     asi_i,
    input  logic                 cyc_start_i,
    input  logic                 burst_more_i,
    input  logic                 ext_ready_n_i,
    input  logic                 reg_we_i,
    input  logic [IDX_W-1:0]     reg_area_i,
    input  logic [1:0]           reg_kind_i,
    input  logic [WORD_W-1:0]    reg_wdata_i,
    output logic [NUM_AREAS-1:0] cs_n_o,
    output logic                 ready_o
);

    localparam int LOW_W = ADDR_W - TAG_W;

    base_t [NUM_AREAS-1:0] base;
    mask_t [NUM_AREAS-1:0] mask;
    wcfg_t [NUM_AREAS-1:0] wcfg;
    logic                  hit;
    logic [IDX_W-1:0]      hit_idx;
    logic [NUM_AREAS-1:0]  hit_sel;
    logic [NUM_AREAS-1:0]  cur_sel;
    logic                  unused_low;

    assign unused_low = ^addr_i[LOW_W-1:0];

    csw_regs #(.NUM_AREAS(NUM_AREAS), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we_i),
        .area_i  (reg_area_i),
        .kind_i  (reg_kind_i),
        .wdata_i (reg_wdata_i),
        .base_o  (base),
        .mask_o  (mask),
        .wcfg_o  (wcfg)
    );

    csw_decode #(.NUM_AREAS(NUM_AREAS), .IDX_W(IDX_W)) u_dec (
        .tag_i  (addr_i[ADDR_W-1 -: TAG_W]),
        .asi_i  (asi_i),
        .base_i (base),
        .mask_i (mask),
        .hit_o  (hit),
        .idx_o  (hit_idx),
        .sel_o  (hit_sel)
    );

    csw_beat #(.NUM_AREAS(NUM_AREAS), .IDX_W(IDX_W)) u_beat (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (cyc_start_i),
        .hit_i       (hit),
        .idx_i       (hit_idx),
        .sel_i       (hit_sel),
        .wcfg_i      (wcfg),
        .more_i      (burst_more_i),
        .ext_rdy_n_i (ext_ready_n_i),
        .sel_o       (cur_sel),
        .rdy_o       (ready_o)
    );

    assign cs_n_o = ~cur_sel;

endmodule

// File: rtl/csw_chk.sv
module csw_chk #(
    parameter int NUM_AREAS = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 burst_more_i,
    input logic [NUM_AREAS-1:0] cs_n_o,
    input logic                 ready_o
);

    logic idle;
    assign idle = &cs_n_o;

    // R5
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R5
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !ready_o) |=> $stable(cs_n_o));

    // R8
    ready_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !idle);

    // R7
    burst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && burst_more_i) |=> $stable(cs_n_o));

    // R11
    cycle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !burst_more_i) |=> idle);

endmodule

bind cs_wait_gen csw_chk #(.NUM_AREAS(NUM_AREAS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_more_i (burst_more_i),
    .cs_n_o       (cs_n_o),
    .ready_o      (ready_o)
);

// File: tb/sim_cs_wait_gen.sv
`timescale 1ns/1ps
module sim_cs_wait_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr_i = '0;
    logic [5:0]  asi_i = '0;
    logic        cyc_start_i = 1'b0;
    logic        burst_more_i = 1'b0;
    logic        ext_ready_n_i = 1'b1;
    logic        reg_we_i = 1'b0;
    logic [2:0]  reg_area_i = '0;
    logic [1:0]  reg_kind_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [5:0]  cs_n_o;
    logic        ready_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] m_base [8];
    logic [31:0] m_mask [8];
    logic [31:0] m_wait [8];

    always #2.5 clk = ~clk;

    cs_wait_gen u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .asi_i(asi_i),
        .cyc_start_i(cyc_start_i), .burst_more_i(burst_more_i),
        .ext_ready_n_i(ext_ready_n_i), .reg_we_i(reg_we_i),
        .reg_area_i(reg_area_i), .reg_kind_i(reg_kind_i),
        .reg_wdata_i(reg_wdata_i), .cs_n_o(cs_n_o), .ready_o(ready_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input int area, input int kind, input logic [31:0] data);
        @(negedge clk);
        reg_we_i = 1'b1; reg_area_i = 3'(area); reg_kind_i = 2'(kind); reg_wdata_i = data;
        @(negedge clk);
        reg_we_i = 1'b0;
        if (area < 6 && kind < 3) begin
            if (kind == 0) m_base[area] = data;
            else if (kind == 1) m_mask[area] = data;
            else m_wait[area] = data;
        end
    endtask

    function automatic int exp_area(input logic [31:0] a, input logic [5:0] s);
        for (int i = 0; i < 6; i++) begin
            logic [31:0] b;
            logic [31:0] m;
            b = m_base[i];
            m = m_mask[i];
            if (b[31] && (((s ^ b[21:16]) & ~m[21:16]) == 6'd0) &&
                (((a[31:16] ^ b[15:0]) & ~m[15:0]) == 16'd0))
                return i;
        end
        return -1;
    endfunction

    function automatic int exp_len(input logic [31:0] cfg, input int cnt, input int ext_at);
        int internal;
        internal = cnt + 2;
        if (cfg[9]) begin
            if (cfg[8] && ext_at > 0 && ext_at < internal) return ext_at;
            return internal;
        end
        return ext_at;
    endfunction

    // one bus cycle; ext_at = cycle within each beat where external ready is low (0 = never)
    task automatic run_cycle(input logic [31:0] a, input logic [5:0] s, input int nbeats,
                             input int ext_at, input bit stray, input bit midwr, input string req);
        int idx;
        logic [31:0] cfg;
        idx = exp_area(a, s);
        cfg = (idx >= 0) ? m_wait[idx] : 32'd0;
        @(negedge clk);
        addr_i = a; asi_i = s; cyc_start_i = 1'b1; burst_more_i = 1'b0; ext_ready_n_i = 1'b1;
        if (idx < 0) begin
            for (int k = 1; k <= 4; k++) begin
                @(negedge clk);
                cyc_start_i = 1'b0;
                #1;
                chk(cs_n_o == 6'h3F, {req, " R5 no-match select"}, int'(cs_n_o), 63);
                chk(ready_o == 1'b0, {req, " R5 no-match ready"}, int'(ready_o), 0);
            end
            return;
        end
        for (int beat = 0; beat < nbeats; beat++) begin
            int cnt;
            int el;
            int got;
            cnt = (beat == 0) ? int'(cfg[3:0]) : int'(cfg[7:4]);
            el  = exp_len(cfg, cnt, ext_at);
            got = -1;
            for (int k = 1; k <= 40 && got < 0; k++) begin
                @(negedge clk);
                cyc_start_i   = (stray && beat == 0 && k == 2);
                addr_i        = (stray && beat == 0 && k == 2) ? 32'h0000_0000 : a;
                asi_i         = (stray && beat == 0 && k == 2) ? 6'd0 : s;
                ext_ready_n_i = !(k == ext_at);
                burst_more_i  = (beat < nbeats - 1);
                reg_we_i      = (midwr && beat == 0 && k == 1);
                reg_area_i    = 3'(idx); reg_kind_i = 2'd2; reg_wdata_i = 32'h0000_0200;
                #1;
                chk(cs_n_o == ~(6'd1 << idx), {req, " R5 select low"}, int'(cs_n_o), int'(~(6'd1 << idx)));
                if (ready_o) got = k;
            end
            chk(got == el, {req, " beat length"}, got, el);
        end
        if (midwr) m_wait[idx] = 32'h0000_0200;
        @(negedge clk);
        cyc_start_i = 1'b0; burst_more_i = 1'b0; ext_ready_n_i = 1'b1; reg_we_i = 1'b0;
        addr_i = a; asi_i = s;
        #1;
        chk(cs_n_o == 6'h3F, {req, " R11 idle after last beat"}, int'(cs_n_o), 63);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_wait[i] = '0;
        end
        m_base[0] = 32'h8000_0000;
        m_mask[0] = 32'h0003_0001;
        m_wait[0] = 32'h0000_0277;

        repeat (3) @(negedge clk);
        #1;
        chk(cs_n_o == 6'h3F, "R1 selects in reset", int'(cs_n_o), 63);
        chk(ready_o == 1'b0, "R1 ready in reset", int'(ready_o), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(cs_n_o == 6'h3F, "R1 selects after reset", int'(cs_n_o), 63);

        // R1 / R3: boot area decode over every ASI and a few addresses
        for (int s = 0; s < 64; s++) run_cycle(32'h0001_2340, 6'(s), 1, 0, 0, 0, "R1 R3 boot");
        run_cycle(32'h0002_0000, 6'd0, 1, 0, 0, 0, "R3 boot bit17");
        run_cycle(32'hFFFF_0000, 6'd1, 1, 0, 0, 0, "R3 boot high");
        run_cycle(32'h0000_0000, 6'd3, 2, 0, 0, 0, "R1 boot burst");

        // R2 / R3 / R4: program areas 1..5; area 3 overlaps area 2
        for (int i = 1; i < 6; i++) begin
            wr(i, 0, 32'h8000_0000 | (32'(i + 8) << 16) | (32'(i) << 12));
            wr(i, 1, (i == 5) ? 32'h003F_0FFF : 32'h0000_0FFF);
            wr(i, 2, 32'h0000_0200 | 32'(i));
        end
        wr(3, 0, m_base[2]);
        for (int i = 1; i < 6; i++)
            for (int s = 0; s < 64; s++)
                run_cycle((32'(i) << 28) | 32'h05A5_0000 >> 4, 6'(s), 1, 0, 0, 0, "R2 R3 R4 sweep");
        for (int i = 1; i < 6; i++)
            for (int s = 8; s < 14; s++)
                run_cycle(32'(i) << 28, 6'(s), 1, 0, 0, 0, "R3 R4 aligned");

        // R6: first-beat count sweep
        for (int f = 0; f < 16; f++) begin
            wr(1, 2, 32'h0000_0200 | 32'(f));
            run_cycle(32'h1000_0000, 6'd9, 1, 0, 0, 0, "R6 first count");
        end
        // R7: burst count sweep
        for (int b = 0; b < 16; b++) begin
            wr(1, 2, 32'h0000_0202 | (32'(b) << 4));
            run_cycle(32'h1000_0000, 6'd9, 3, 0, 0, 0, "R7 burst count");
        end
        // R8: external ready only
        for (int e = 1; e < 9; e++) begin
            wr(1, 2, 32'h0000_0055);
            run_cycle(32'h1000_0000, 6'd9, 2, e, 0, 0, "R8 external only");
        end
        // R9: external ready ignored without override
        for (int e = 1; e < 8; e++) begin
            wr(1, 2, 32'h0000_0206);
            run_cycle(32'h1000_0000, 6'd9, 1, e, 0, 0, "R9 external ignored");
        end
        // R10: override, earlier ready wins
        for (int f = 0; f < 8; f++)
            for (int e = 1; e < 11; e++) begin
                wr(1, 2, 32'h0000_0300 | (32'(f) << 4) | 32'(f));
                run_cycle(32'h1000_0000, 6'd9, 2, e, 0, 0, "R10 override");
            end

        // R12: ignored writes, then mid-cycle write
        wr(1, 2, 32'h0000_0203);
        wr(6, 0, 32'h8000_7777);
        wr(7, 0, 32'h8000_7777);
        wr(1, 3, 32'h0000_0000);
        run_cycle(32'h7777_0000, 6'd0, 1, 0, 0, 0, "R12 area 6/7 ignored");
        run_cycle(32'h1000_0000, 6'd9, 1, 0, 0, 0, "R12 kind 3 ignored");
        wr(1, 2, 32'h0000_0209);
        run_cycle(32'h1000_0000, 6'd9, 1, 0, 0, 1, "R12 mid-cycle write");
        run_cycle(32'h1000_0000, 6'd9, 1, 0, 0, 0, "R12 write applies next");

        // R13: stray start during a cycle
        wr(1, 2, 32'h0000_0205);
        run_cycle(32'h1000_0000, 6'd9, 2, 0, 1, 0, "R13 stray start");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule